// File: doc/BRIEF.md
# Dual-Mode Per-Processor Counter Timer

This block is a counter/timer for a single processor core. It is driven by a 32-bit word-addressed register bus. One counter datapath serves two modes. A mode bit generated outside the block selects the mode, and the block latches that bit when it sees a change strobe.

In limit mode the block is a periodic interval timer. A prescaler produces one count step every `TICK_DIV` clocks, which is 500 ns at the intended clock. The count runs up to a 31-bit limit held in the register units of the bus. On each wrap the block sets a reached flag and raises `irq`. Software reads the limit word to acknowledge the interrupt.

In user mode the same datapath becomes a free-running 63-bit cycle counter. Software reads it as a high word and a low word. It can stop the counter and start it again, and either count word can be written to restart it from zero. In user mode the counter never interrupts.

Count values on the bus are in register units. One step adds 1 at bit 9, and bits 8:0 always read as zero. Reads are registered: data appears on `bus_rdata` with `bus_rvalid` one cycle after `bus_re`. The bus has no back-pressure. A read or a write is accepted in every cycle in which its enable is high, and a read may be issued in every cycle.

Top module: `cpu_ctr_timer`

## Requirements
- R1: After reset the count and prescaler are zero, the counter is running (offset 3 reads 1), the reached flag is clear, `irq` is low, and the limit is the default 0x7FFFFE00. In limit mode offset 0 reads this default.
- R2: While running, the count advances by one step every `TICK_DIV` clocks. A count read places the step count at bit 9 and up, with bits 8:0 zero.
- R3: In limit mode, a write to offset 0 sets the limit to the data bits 30:9 (other bits dropped) and clears the count and prescaler. It also lowers `irq`. If the masked value is zero, the limit becomes 0x7FFFFE00.
- R4: In limit mode, a write to offset 2 sets the limit with the same masking and zero rule as offset 0, but leaves the count and prescaler untouched.
- R5: In limit mode, when a step would bring the count to the limit (in steps), the count wraps to zero and both the reached flag and `irq` are set. The reached flag is bit 31 of an offset-1 read, above the count bits 30:9. A count already at or past a newly lowered limit wraps on its next step.
- R6: In limit mode, an offset-0 read returns the limit and clears the reached flag and `irq`. If a wrap happens on the same edge, the wrap wins.
- R7: In limit mode, writes to offset 1 and offset 3 have no effect on count, limit, running flag or `irq`.
- R8: In user mode, offset 0 reads count register-unit bits 62:32 (read bit 31 is zero). Offset 1 reads bits 31:0, with bits 8:0 zero.
- R9: In user mode, a write to offset 0 or offset 1 clears the count and prescaler and lowers `irq`. The written data is ignored.
- R10: In user mode, writing offset 3 with bit 0 = 0 stops the counter and bit 0 = 1 starts it. A stopped counter holds its count and prescaler phase, so counting resumes with no lost step. Offset 3 reads the running flag in bit 0.
- R11: In user mode the counter wraps after 2^54-1 steps, and `irq` stays low at all times.
- R12: A pulse on `mode_chg` latches `mode_user` (1 = user mode), clears the count and prescaler, and sets the counter running. It also lowers `irq` and restores the default limit.
- R13: Reads of offset 2 and of offsets 4 and above return zero. All read data reflects state before the read edge and is valid on the following cycle with `bus_rvalid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_user | input | 1 | Mode to adopt at reset or on a change strobe (1 = user) |
| mode_chg | input | 1 | One-cycle strobe: adopt `mode_user` and restart the counter |
| bus_we | input | 1 | Register write enable |
| bus_re | input | 1 | Register read enable |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_rvalid` |
| bus_rvalid | output | 1 | Read data valid, one cycle after `bus_re` |
| irq | output | 1 | Limit-mode interrupt, level |

## Verification
Any wrong count or prescaler state shows up in the next count read as a step value that differs from the elapsed-clock arithmetic. A broken stop or start path shows up the same way, because the frozen span shifts every later read. A wrong wrap or limit decode shows up on `irq` in the exact cycle after the `TICK_DIV`×limit-th edge, so the bench samples the cycle before and the cycle after that edge. State that leaks across a mode change shows up in the first read after the strobe, as a nonzero count, a stopped flag or a non-default limit.

// File: rtl/cpu_ctr_pkg.sv
package cpu_ctr_pkg;
  localparam int WORD_W   = 32;
  localparam int SUB_W    = 9;              // register units per step: bit 9
  localparam int CNT_W    = 63 - SUB_W;     // user-mode step counter width
  localparam int LIM_HI   = 30;             // top bit of the limit field
  localparam int LSTEP_W  = LIM_HI + 1 - SUB_W;
  localparam logic [WORD_W-1:0] LIM_MASK = 32'h7FFF_FE00;

  typedef enum logic [1:0] {
    REG_HI_LIM  = 2'd0,
    REG_LO_CNT  = 2'd1,
    REG_LIM_SFT = 2'd2,
    REG_RUN     = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/cpu_ctr_prescale.sv
module cpu_ctr_prescale #(
  parameter int DIV = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (!rst_n)        pre <= '0;
    else if (clr)      pre <= '0;
    else if (run)      pre <= (pre == LAST) ? '0 : pre + 1'b1;
  end

  assign tick = run && !clr && (pre == LAST);

  // R10: a step can only be issued while the counter runs
  a_r10_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);
  // R10: stopped prescaler keeps its phase
  a_r10_phase_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(pre));
endmodule

// File: rtl/cpu_ctr_count.sv
module cpu_ctr_count #(
  parameter int CW = 54
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr,
  input  logic [CW-1:0] wrap_at,
  output logic [CW-1:0] cnt,
  output logic          hit
);
  logic [CW:0] nxt;

  assign nxt = {1'b0, cnt} + 1'b1;
  assign hit = tick && (nxt >= {1'b0, wrap_at});

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (tick)  cnt <= hit ? '0 : nxt[CW-1:0];
  end

  a_r3_clear_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
  a_r10_hold_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !clr) |=> $stable(cnt));
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && !hit) |=> (cnt == $past(cnt) + 1'b1));
  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !clr) |=> (cnt == '0));
endmodule

// File: rtl/cpu_ctr_regs.sv
module cpu_ctr_regs
  import cpu_ctr_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_user,
  input  logic              mode_chg,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              hit,
  output logic              run,
  output logic              clr,
  output logic [CNT_W-1:0]  wrap_at,
  output logic [WORD_W-1:0] rdata,
  output logic              rvalid,
  output logic              irq
);
  logic              user_q, run_q, reached_q, irq_q;
  logic [WORD_W-1:0] lim_q, lim_nx, lim_msk, rd_mux;
  logic              in_win;
  reg_sel_e          sel;
  logic              wr_hi, wr_lo, wr_sft, wr_run, rd_hi;

  assign in_win = (addr < ADDR_W'(4));
  assign sel    = reg_sel_e'(addr[1:0]);

  always_comb begin
    wr_hi  = we && in_win && (sel == REG_HI_LIM);
    wr_lo  = we && in_win && (sel == REG_LO_CNT);
    wr_sft = we && in_win && (sel == REG_LIM_SFT);
    wr_run = we && in_win && (sel == REG_RUN);
    rd_hi  = re && in_win && (sel == REG_HI_LIM);
  end

  assign lim_msk = wdata & LIM_MASK;
  assign lim_nx  = (lim_msk == '0) ? LIM_MASK : lim_msk;
  assign clr     = mode_chg || (!user_q && wr_hi) || (user_q && (wr_hi || wr_lo));

  always_ff @(posedge clk) begin
    if (!rst_n)        user_q <= mode_user;
    else if (mode_chg) user_q <= mode_user;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                run_q <= 1'b1;
    else if (mode_chg)         run_q <= 1'b1;
    else if (wr_run && user_q) run_q <= wdata[0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              lim_q <= LIM_MASK;
    else if (mode_chg)                       lim_q <= LIM_MASK;
    else if ((wr_hi || wr_sft) && !user_q)   lim_q <= lim_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 reached_q <= 1'b0;
    else if (hit && !user_q)    reached_q <= 1'b1;
    else if (rd_hi && !user_q)  reached_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 irq_q <= 1'b0;
    else if (mode_chg)          irq_q <= 1'b0;
    else if (hit && !user_q)    irq_q <= 1'b1;
    else if ((rd_hi && !user_q) || wr_hi || (wr_lo && user_q))
                                irq_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (in_win) begin
      unique case (sel)
        REG_HI_LIM: rd_mux = user_q ? {1'b0, cnt[CNT_W-1:WORD_W-SUB_W]} : lim_q;
        REG_LO_CNT: rd_mux = user_q ? {cnt[WORD_W-SUB_W-1:0], {SUB_W{1'b0}}}
                                    : {reached_q, cnt[LSTEP_W-1:0], {SUB_W{1'b0}}};
        REG_RUN:    rd_mux = {{(WORD_W-1){1'b0}}, run_q};
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= re;
      if (re) rdata <= rd_mux;
    end
  end

  assign wrap_at = user_q ? {CNT_W{1'b1}} : CNT_W'(lim_q[LIM_HI:SUB_W]);
  assign run     = run_q;
  assign irq     = irq_q;

  a_r11_user_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    user_q |-> !irq_q);
  a_r12_restart: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (run_q && !irq_q && lim_q == LIM_MASK));
  a_r6_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hi && !user_q && !hit && !mode_chg) |=> (!irq_q && !reached_q));
  a_r5_flags_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !user_q && !mode_chg) |=> (irq_q && reached_q));
  a_r10_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_run && user_q && !mode_chg && !wdata[0]) |=> !run_q);
  a_r13_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    re |=> rvalid);
endmodule

// File: rtl/cpu_ctr_timer.sv
module cpu_ctr_timer
  import cpu_ctr_pkg::*;
#(
  parameter int TICK_DIV = 125,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_user,
  input  logic              mode_chg,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              irq
);
  logic             run, clr, tick, hit;
  logic [CNT_W-1:0] cnt, wrap_at;

  cpu_ctr_prescale #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .tick(tick)
  );

  cpu_ctr_count #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clr(clr),
    .wrap_at(wrap_at), .cnt(cnt), .hit(hit)
  );

  cpu_ctr_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .mode_user(mode_user), .mode_chg(mode_chg),
    .we(bus_we), .re(bus_re), .addr(bus_addr), .wdata(bus_wdata),
    .cnt(cnt), .hit(hit), .run(run), .clr(clr), .wrap_at(wrap_at),
    .rdata(bus_rdata), .rvalid(bus_rvalid), .irq(irq)
  );
endmodule

// File: tb/test_cpu_ctr_timer.sv
module test_cpu_ctr_timer;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_user = 1'b0, mode_chg = 1'b0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, irq;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cpu_ctr_timer #(.TICK_DIV(DIV), .ADDR_W(3)) i_cpu_ctr_timer (
    .clk(clk), .rst_n(rst_n), .mode_user(mode_user), .mode_chg(mode_chg),
    .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected count word from the number of running edges before the read edge
  function automatic logic [31:0] cword(input int active);
    return 32'(active / DIV) << 9;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d, output int e);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; e = cyc + 1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d, output int e);
    bus_re = 1'b1; bus_addr = a; e = cyc + 1;
    @(posedge clk); @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic strobe(input logic m, output int e);
    mode_user = m; mode_chg = 1'b1; e = cyc + 1;
    @(posedge clk); @(negedge clk);
    mode_chg = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2;
    int e0, e, es, eg, em, n, tmp;
    tmp = int'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 32'd0);
    rd(3'd3, d, e); chk("R1 running", d, 32'd1);
    chk("R13 rvalid", {31'b0, bus_rvalid}, 32'd1);
    @(negedge clk); chk("R13 rvalid drop", {31'b0, bus_rvalid}, 32'd0);
    rd(3'd1, d, e); chk("R1 reached/count", d[31], 1'b0);
    rd(3'd0, d, e); chk("R1 default limit", d, 32'h7FFF_FE00);

    // R3/R5/R6 random limits
    for (int k = 0; k < 5; k++) begin
      n = 2 + int'($urandom_range(0, 12));
      wr(3'd0, (32'(n) << 9) | ($urandom & 32'h8000_01FF), e0);
      chk("R3 irq low after write", {31'b0, irq}, 32'd0);
      while (cyc < e0 + DIV * n - 1) @(negedge clk);
      chk("R5 irq before wrap", {31'b0, irq}, 32'd0);
      @(negedge clk);
      chk("R5 irq at wrap", {31'b0, irq}, 32'd1);
      rd(3'd1, d, e); chk("R5 reached bit", d[31], 1'b1);
      rd(3'd0, d, e); chk("R3 limit masked", d, 32'(n) << 9);
      chk("R6 irq cleared", {31'b0, irq}, 32'd0);
      rd(3'd1, d, e); chk("R6 reached cleared", d[31], 1'b0);
    end

    // R6 read and wrap on the same edge: wrap wins
    n = 3;
    wr(3'd0, 32'(n) << 9, e0);
    while (cyc < e0 + DIV * n - 1) @(negedge clk);
    rd(3'd0, d, e);
    chk("R6 read data on wrap edge", d, 32'(n) << 9);
    chk("R6 wrap wins irq", {31'b0, irq}, 32'd1);
    rd(3'd1, d, e); chk("R6 wrap wins reached", d, 32'h8000_0000 | cword(e - e0 - 1 - DIV * n));
    rd(3'd0, d, e); rd(3'd1, d, e);
    chk("R6 second read clears", d[31], 1'b0);

    // R2 count reads
    wr(3'd0, 32'd1000 << 9, e0);
    for (int k = 0; k < 4; k++) begin
      repeat ($urandom_range(0, 30)) @(negedge clk);
      rd(3'd1, d, e); chk("R2 count", d, cword(e - e0 - 1));
    end
    // R4 soft limit keeps count
    wr(3'd2, 32'd500 << 9, e);
    repeat (5) @(negedge clk);
    rd(3'd1, d, e); chk("R4 count kept", d, cword(e - e0 - 1));
    // R7 writes ignored in limit mode
    wr(3'd1, $urandom, e);
    wr(3'd3, 32'd0, e);
    rd(3'd3, d, e); chk("R7 run unchanged", d, 32'd1);
    rd(3'd1, d, e); chk("R7 count unchanged", d, cword(e - e0 - 1));
    rd(3'd0, d, e); chk("R4 soft limit value", d, 32'd500 << 9);
    // R3 zero limit
    wr(3'd0, 32'h8000_01FF, e);
    rd(3'd0, d, e); chk("R3 zero limit", d, 32'h7FFF_FE00);
    // R13 unused offsets
    for (int a = 2; a < 8; a++) begin
      if (a == 3) continue;
      rd(3'(a), d, e); chk("R13 zero offset", d, 32'd0);
    end

    // R12 switch to user with irq pending
    wr(3'd0, 32'd2 << 9, e0);
    repeat (12) @(negedge clk);
    chk("R5 pending before switch", {31'b0, irq}, 32'd1);
    strobe(1'b1, em);
    chk("R12 irq low", {31'b0, irq}, 32'd0);
    rd(3'd3, d, e); chk("R12 running", d, 32'd1);
    repeat (9) @(negedge clk);
    rd(3'd1, d, e); chk("R8 low word", d, cword(e - em - 1));
    rd(3'd0, d, e); chk("R8 high word", d, 32'd0);

    // R9 user writes restart count
    for (int k = 0; k < 2; k++) begin
      repeat (7) @(negedge clk);
      wr(3'(k), $urandom, e0);
      repeat ($urandom_range(0, 20)) @(negedge clk);
      rd(3'd1, d, e); chk("R9 restart", d, cword(e - e0 - 1));
    end

    // R10 stop / start
    repeat (6) @(negedge clk);
    wr(3'd3, 32'hFFFF_FFFE, es);
    rd(3'd3, d, e); chk("R10 stopped flag", d, 32'd0);
    repeat (9) @(negedge clk);
    rd(3'd1, d, e);
    repeat (7) @(negedge clk);
    rd(3'd1, d2, e);
    chk("R10 hold", d2, d);
    chk("R10 hold value", d, cword(es - e0));
    wr(3'd3, 32'd1, eg);
    wr(3'd3, 32'd1, e);
    repeat ($urandom_range(1, 20)) @(negedge clk);
    rd(3'd1, d, e); chk("R10 resume", d, cword((es - e0) + (e - 1 - eg)));
    rd(3'd3, d, e); chk("R10 running flag", d, 32'd1);
    chk("R11 no irq in user", {31'b0, irq}, 32'd0);

    // R12 switch back while stopped
    wr(3'd3, 32'd0, e);
    strobe(1'b0, em);
    rd(3'd3, d, e); chk("R12 restarted", d, 32'd1);
    rd(3'd0, d, e); chk("R12 default limit", d, 32'h7FFF_FE00);
    rd(3'd1, d, e); chk("R12 count from zero", d, cword(e - em - 1));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule